// File: doc/BRIEF.md
# Host-to-Agent Command Mailbox

This block is a register window of 256 bytes that lets a host processor pass a command to a service agent on the controller side of the chip. The host first fills an outbound payload of up to sixteen bytes and, when the command needs them, two 32-bit address pointers. It then writes a command word. That write marks the mailbox busy and sends a single-cycle request pulse to the agent.

The agent reads the command, the payload and the pointers from dedicated outputs. It places any reply words into a sixteen-byte inbound buffer through a write port. It ends the exchange with a done strobe that carries an error flag, an error code and an initiator id. The host polls the busy bit in the status word and then reads the error information and the reply. If the command word asked for it, completion also produces a one-cycle interrupt pulse to the host. This pulse is edge-type and needs no acknowledgement.

Host reads are registered: the read data appears on the clock edge that samples the read strobe. Only aligned word addresses are decoded.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, the status word at offset 0x04 reads zero, every reply word reads zero, and the agent request and host interrupt outputs are low.
- R2: A host write to offset 0x00 while not busy does three things. It stores the word on `agt_cmd`, it sets busy (status bit 0) at that edge, and it raises `agt_irq` for exactly one cycle starting at that edge.
- R3: A host write to offset 0x00 while busy does not change `agt_cmd` and does not pulse `agt_irq`. It sets a sticky overrun flag in status bit 2, which stays set until reset.
- R4: A done strobe while busy clears busy at that edge. At the same edge, status bit 1 takes the error flag, status bits [23:16] take the error code, and status bits [15:8] take the initiator id.
- R5: Status bits [7:4] echo bits [15:12] of the last accepted command word. Status bits [31:24] and bit 3 read zero.
- R6: When bit 8 of the accepted command word is set, a completing done strobe raises `host_irq` for exactly one cycle. When bit 8 is clear, `host_irq` stays low.
- R7: A done strobe while not busy has no effect on the status word.
- R8: Host writes to offsets 0x80, 0x84, 0x88 and 0x8C appear on `agt_payload` word 0 to 3, where word k occupies bits [32k+31:32k]. Writes to 0x08 appear on `agt_sptr`, and writes to 0x0C appear on `agt_dptr`.
- R9: A reply word written through the agent port with index k reads back at host offset 0x90 + 4k.
- R10: Reads of the write-only offsets 0x00, 0x08, 0x0C and 0x80 to 0x8C return zero, as do misaligned addresses. Host writes to 0x04 and to 0x90 to 0x9C are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_addr | input | 8 | Host byte address within the window |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 32 | Host write data |
| h_rd | input | 1 | Host read strobe |
| h_rdata | output | 32 | Host read data, registered |
| host_irq | output | 1 | Completion interrupt pulse to the host |
| agt_irq | output | 1 | New-command pulse to the agent |
| agt_cmd | output | 32 | Last accepted command word |
| agt_payload | output | 128 | Outbound payload, four words |
| agt_sptr | output | 32 | Source pointer |
| agt_dptr | output | 32 | Destination pointer |
| agt_rsp_we | input | 1 | Reply word write enable |
| agt_rsp_idx | input | 2 | Reply word index |
| agt_rsp_data | input | 32 | Reply word data |
| agt_done | input | 1 | Completion strobe from the agent |
| agt_err | input | 1 | Error flag, sampled with done |
| agt_err_code | input | 8 | Error code, sampled with done |
| agt_init_id | input | 8 | Initiator id, sampled with done |

## Verification
The hardest state to reach is a command write that arrives while a previous command is still in flight. Reaching it needs a command to be accepted and the agent to be held back from completing. The bench creates this by not driving the done strobe until it has issued a second command write and checked that the request pulse, the command outputs and the overrun flag behave as R3 requires. A spurious done strobe is then issued from the idle state to show that completion only acts on an outstanding command.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int BUF_WORDS = 4,
  parameter logic [7:0] CMD_OFS  = 8'h00,
  parameter logic [7:0] STAT_OFS = 8'h04,
  parameter logic [7:0] SPTR_OFS = 8'h08,
  parameter logic [7:0] DPTR_OFS = 8'h0C,
  parameter logic [3:0] WBUF_PG  = 4'h8,
  parameter logic [3:0] RBUF_PG  = 4'h9,
  localparam int IW = $clog2(BUF_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              h_addr,
  input  logic                    h_wr,
  input  logic [31:0]             h_wdata,
  input  logic                    h_rd,
  output logic [31:0]             h_rdata,
  output logic                    host_irq,
  output logic                    agt_irq,
  output logic [31:0]             agt_cmd,
  output logic [32*BUF_WORDS-1:0] agt_payload,
  output logic [31:0]             agt_sptr,
  output logic [31:0]             agt_dptr,
  input  logic                    agt_rsp_we,
  input  logic [IW-1:0]           agt_rsp_idx,
  input  logic [31:0]             agt_rsp_data,
  input  logic                    agt_done,
  input  logic                    agt_err,
  input  logic [7:0]              agt_err_code,
  input  logic [7:0]              agt_init_id
);

  logic        busy_q, err_q, ovr_q;
  logic [7:0]  ecode_q, init_q;
  logic [31:0] wbuf_q [BUF_WORDS];
  logic [31:0] rbuf_q [BUF_WORDS];
  logic [31:0] status, rd_mux;

  wire aligned  = (h_addr[1:0] == 2'b00);
  wire cmd_wr   = h_wr && (h_addr == CMD_OFS);
  wire accept   = cmd_wr && !busy_q;
  wire finish   = agt_done && busy_q;
  wire wb_hit   = aligned && (h_addr[7:4] == WBUF_PG);
  wire rb_hit   = aligned && (h_addr[7:4] == RBUF_PG);
  wire [IW-1:0] widx = h_addr[IW+1:2];

  assign status = {8'h00, ecode_q, init_q, agt_cmd[15:12], 1'b0, ovr_q, err_q, busy_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      ovr_q    <= 1'b0;
      ecode_q  <= '0;
      init_q   <= '0;
      agt_cmd  <= '0;
      agt_irq  <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      agt_irq  <= accept;
      host_irq <= finish && agt_cmd[8];
      if (cmd_wr && busy_q) ovr_q <= 1'b1;
      if (accept) begin
        agt_cmd <= h_wdata;
        busy_q  <= 1'b1;
      end else if (finish) begin
        busy_q  <= 1'b0;
        err_q   <= agt_err;
        ecode_q <= agt_err_code;
        init_q  <= agt_init_id;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agt_sptr <= '0;
      agt_dptr <= '0;
    end else if (h_wr) begin
      if (h_addr == SPTR_OFS) agt_sptr <= h_wdata;
      if (h_addr == DPTR_OFS) agt_dptr <= h_wdata;
    end
  end

  for (genvar k = 0; k < BUF_WORDS; k++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wbuf_q[k] <= '0;
        rbuf_q[k] <= '0;
      end else begin
        if (h_wr && wb_hit && widx == IW'(k)) wbuf_q[k] <= h_wdata;
        if (agt_rsp_we && agt_rsp_idx == IW'(k)) rbuf_q[k] <= agt_rsp_data;
      end
    end
    assign agt_payload[32*k +: 32] = wbuf_q[k];
  end

  always_comb begin
    rd_mux = '0;
    if (h_addr == STAT_OFS) rd_mux = status;
    else if (rb_hit)        rd_mux = rbuf_q[widx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    h_rdata <= '0;
    else if (h_rd) h_rdata <= rd_mux;
  end

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        h_wr,
  input logic [7:0]  h_addr,
  input logic        busy,
  input logic        ovr,
  input logic        agt_irq,
  input logic        agt_done,
  input logic [31:0] agt_cmd,
  input logic        host_irq
);
  wire cmd_wr = h_wr && (h_addr == 8'h00);

  a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> busy);
  a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    agt_irq |=> !agt_irq);
  a_r3_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> ($stable(agt_cmd) && !agt_irq));
  a_r3_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);
  a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && agt_done) |=> !busy);
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(busy && agt_done && agt_cmd[8]));
  a_r7_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && agt_done && !cmd_wr) |=> !busy);
endmodule

bind ipc_mailbox ipc_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .busy(busy_q),
  .ovr(ovr_q), .agt_irq(agt_irq), .agt_done(agt_done), .agt_cmd(agt_cmd),
  .host_irq(host_irq)
);

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   h_addr = '0;
  logic         h_wr = 1'b0, h_rd = 1'b0;
  logic [31:0]  h_wdata = '0;
  logic [31:0]  h_rdata;
  logic         host_irq, agt_irq;
  logic [31:0]  agt_cmd, agt_sptr, agt_dptr;
  logic [127:0] agt_payload;
  logic         agt_rsp_we = 1'b0;
  logic [1:0]   agt_rsp_idx = '0;
  logic [31:0]  agt_rsp_data = '0;
  logic         agt_done = 1'b0, agt_err = 1'b0;
  logic [7:0]   agt_err_code = '0, agt_init_id = '0;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ipc_mailbox i_ipc_mailbox (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata),
    .h_rd(h_rd), .h_rdata(h_rdata), .host_irq(host_irq), .agt_irq(agt_irq),
    .agt_cmd(agt_cmd), .agt_payload(agt_payload), .agt_sptr(agt_sptr),
    .agt_dptr(agt_dptr), .agt_rsp_we(agt_rsp_we), .agt_rsp_idx(agt_rsp_idx),
    .agt_rsp_data(agt_rsp_data), .agt_done(agt_done), .agt_err(agt_err),
    .agt_err_code(agt_err_code), .agt_init_id(agt_init_id)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); h_addr = a; h_rd = 1'b1;
    @(negedge clk); h_rd = 1'b0; d = h_rdata;
  endtask

  task automatic done(input logic e, input logic [7:0] code, input logic [7:0] id);
    @(negedge clk); agt_done = 1'b1; agt_err = e; agt_err_code = code; agt_init_id = id;
    @(negedge clk); agt_done = 1'b0;
  endtask

  task automatic rsp(input logic [1:0] k, input logic [31:0] d);
    @(negedge clk); agt_rsp_we = 1'b1; agt_rsp_idx = k; agt_rsp_data = d;
    @(negedge clk); agt_rsp_we = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    hread(8'h04, d); check("R1 status", d, 0);
    hread(8'h90, d); check("R1 reply0", d, 0);
    check("R1 irqs", {agt_irq, host_irq}, 0);
  endtask

  task automatic t_accept;
    logic [31:0] d;
    hwrite(8'h00, 32'h000C31A5);
    check("R2 req pulse", agt_irq, 1);
    check("R2 cmd", agt_cmd, 32'h000C31A5);
    @(negedge clk); check("R2 req one cycle", agt_irq, 0);
    hread(8'h04, d); check("R2 R5 busy and id", d, 32'h31);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    hwrite(8'h00, 32'h00005002);
    check("R3 no req", agt_irq, 0);
    check("R3 cmd held", agt_cmd, 32'h000C31A5);
    hread(8'h04, d); check("R3 overrun flag", d, 32'h35);
  endtask

  task automatic t_done_ioc;
    logic [31:0] d;
    done(1'b1, 8'h5A, 8'h21);
    check("R6 host irq", host_irq, 1);
    @(negedge clk); check("R6 irq one cycle", host_irq, 0);
    hread(8'h04, d); check("R4 status after done", d, 32'h005A2136);
  endtask

  task automatic t_done_quiet;
    logic [31:0] d;
    hwrite(8'h00, 32'h00002010);
    check("R2 second accept", agt_cmd, 32'h00002010);
    done(1'b0, 8'h00, 8'h07);
    check("R6 no irq without bit8", host_irq, 0);
    @(negedge clk); check("R6 no irq later", host_irq, 0);
    hread(8'h04, d); check("R4 R3 status", d, 32'h00000724);
    done(1'b1, 8'hFF, 8'hEE);
    hread(8'h04, d); check("R7 idle done ignored", d, 32'h00000724);
  endtask

  task automatic t_outbound;
    logic [31:0] d;
    for (int k = 0; k < 4; k++) hwrite(8'h80 + 8'(4*k), 32'hA0000000 + k);
    hwrite(8'h08, 32'h11112222);
    hwrite(8'h0C, 32'h33334444);
    check("R8 payload", agt_payload, {32'hA0000003, 32'hA0000002, 32'hA0000001, 32'hA0000000});
    check("R8 sptr", agt_sptr, 32'h11112222);
    check("R8 dptr", agt_dptr, 32'h33334444);
    hread(8'h80, d); check("R10 wbuf reads zero", d, 0);
    hread(8'h08, d); check("R10 sptr reads zero", d, 0);
    hread(8'h00, d); check("R10 cmd reads zero", d, 0);
  endtask

  task automatic t_reply;
    logic [31:0] d;
    for (int k = 0; k < 4; k++) rsp(2'(k), 32'hC0DE0000 + k);
    for (int k = 0; k < 4; k++) begin
      hread(8'h90 + 8'(4*k), d); check("R9 reply word", d, 32'hC0DE0000 + k);
    end
    hwrite(8'h94, 32'hDEADBEEF);
    hread(8'h94, d); check("R10 reply write ignored", d, 32'hC0DE0001);
    hwrite(8'h04, 32'hFFFFFFFF);
    hread(8'h04, d); check("R10 status write ignored", d, 32'h00000724);
    hread(8'h91, d); check("R10 misaligned zero", d, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_accept;
    t_overrun;
    t_done_ioc;
    t_done_quiet;
    t_outbound;
    t_reply;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule